// File: doc/BRIEF.md
# Dual-Issue Instruction Queue and Dispatcher

This block sits between instruction fetch and three reservation stations (integer, load/store and system-register). It keeps up to six decoded instructions in program order. Each cycle it reports how many slots are free, takes zero, one or two new instructions from fetch, and offers the two oldest ones for dispatch. An instruction goes out when its station is ready, none of its registers is busy on the scoreboard, and no serialization rule holds it back.

Dispatch never reorders. If the head cannot go, nothing behind it goes either. A younger instruction is also held when it uses the destination of the older one in the same pair. A serializing instruction leaves only from the head of the queue, only when the pipeline behind dispatch is idle, and always alone. A flush discards the whole queue in a single cycle.

Dispatch outputs are combinational, computed from the queue state and the current station, scoreboard and pipeline inputs. A station takes its instruction at the next clock edge whenever `dsp_valid` is high.

Top module: `iq_dispatch2`

## Requirements
- R1: The queue holds at most six instructions. `free_slots` always equals six minus the current occupancy and reads 6 after reset.
- R2: The instruction word layout is: unit [1:0], serialize [2], dst-valid [3], dst [8:4], src1-valid [9], src1 [14:10], src2-valid [15], src2 [20:16], payload [28:21]. Fetch writes min(`fetch_cnt`, 2, `free_slots`) instructions per cycle, with `fetch_insn0` older than `fetch_insn1`. Instructions that do not fit are dropped. A `fetch_cnt` of 3 counts as 2.
- R3: At most two instructions are offered per cycle, oldest on lane 0. `dsp_valid[1]` is never high without `dsp_valid[0]`. Each instruction that is offered leaves the queue at the next edge.
- R4: Unit code 0 is routed to `rs_ready[0]` (integer) and code 1 to `rs_ready[1]` (load/store). Codes 2 and 3 are routed to `rs_ready[2]` (system-register). An instruction whose station is not ready is held, and `dsp_unit` carries the instruction's unit code.
- R5: An instruction is held while `reg_busy` is set for any of its valid source registers or its valid destination register.
- R6: The younger instruction of a pair is held when it reads or writes the register that the older one writes.
- R7: Dispatch is in order. When the head is held, the second instruction is held too, even if it could go on its own.
- R8: A serializing instruction dispatches only from the head, only while `pipe_busy` is low, and never together with a second instruction. A serializing instruction in the second position waits until it reaches the head.
- R9: While `flush` is high, nothing is dispatched and fetch is ignored. In the cycle after a flush the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all queued instructions |
| fetch_cnt | input | 2 | Number of valid fetch instructions this cycle |
| fetch_insn0 | input | 29 | Older fetched instruction |
| fetch_insn1 | input | 29 | Younger fetched instruction |
| free_slots | output | 3 | Number of empty queue slots |
| rs_ready | input | 3 | Station ready: bit0 integer, bit1 load/store, bit2 system |
| reg_busy | input | 32 | Scoreboard, one bit per register with a pending write |
| pipe_busy | input | 1 | Instructions are still in flight past dispatch |
| dsp_valid | output | 2 | Dispatch lane valids, bit 0 oldest |
| dsp_unit0 | output | 2 | Unit code on lane 0 |
| dsp_unit1 | output | 2 | Unit code on lane 1 |
| dsp_insn0 | output | 29 | Instruction on lane 0 |
| dsp_insn1 | output | 29 | Instruction on lane 1 |

## Verification
Payload-tagged instructions with no register use are pushed until the queue is full and then drained. This shows the write order, clamping to the free space and the dropping of overflow. Pairs are then built where only one gating factor differs at a time: station readiness, a busy source or destination, an intra-pair dependency, a blocked head with a free follower, and a serializing instruction at the head or in the second slot. This separates each hold rule from the others. A flush issued while the queue is loaded and fetch is active shows that both dispatch and write are suppressed.

// File: rtl/iq_dispatch2.sv
module iq_dispatch2 #(
  parameter int DEPTH = 6,
  parameter int RW    = 5,
  parameter int PW    = 8,
  localparam int IW   = 6 + 3*RW + PW,
  localparam int NREG = 1 << RW,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [1:0]    fetch_cnt,
  input  logic [IW-1:0] fetch_insn0,
  input  logic [IW-1:0] fetch_insn1,
  output logic [CW-1:0] free_slots,
  input  logic [2:0]    rs_ready,
  input  logic [NREG-1:0] reg_busy,
  input  logic          pipe_busy,
  output logic [1:0]    dsp_valid,
  output logic [1:0]    dsp_unit0,
  output logic [1:0]    dsp_unit1,
  output logic [IW-1:0] dsp_insn0,
  output logic [IW-1:0] dsp_insn1
);
  localparam int PTRW = $clog2(DEPTH);
  localparam int D_LO = 4;
  localparam int H1   = 4 + RW;
  localparam int S1LO = 5 + RW;
  localparam int H2   = 5 + 2*RW;
  localparam int S2LO = 6 + 2*RW;

  logic [IW-1:0]   q [DEPTH];
  logic [PTRW-1:0] rd, wr;
  logic [CW-1:0]   cnt;

  function automatic logic [PTRW-1:0] nxt(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic hz(input logic [IW-1:0] i, input logic [NREG-1:0] b);
    return (i[3]  && b[i[D_LO +: RW]]) ||
           (i[H1] && b[i[S1LO +: RW]]) ||
           (i[H2] && b[i[S2LO +: RW]]);
  endfunction

  function automatic logic rdy(input logic [IW-1:0] i, input logic [2:0] r);
    return (i[1:0] == 2'd0) ? r[0] : (i[1:0] == 2'd1) ? r[1] : r[2];
  endfunction

  function automatic logic dep(input logic [IW-1:0] o, input logic [IW-1:0] y);
    logic [RW-1:0] d;
    d = o[D_LO +: RW];
    return o[3] && ((y[H1] && y[S1LO +: RW] == d) ||
                    (y[H2] && y[S2LO +: RW] == d) ||
                    (y[3]  && y[D_LO +: RW] == d));
  endfunction

  wire [PTRW-1:0] rd1 = nxt(rd);
  wire [PTRW-1:0] wr1 = nxt(wr);
  wire [IW-1:0]   i0  = q[rd];
  wire [IW-1:0]   i1  = q[rd1];

  assign free_slots = CW'(DEPTH) - cnt;

  wire [1:0] want = (fetch_cnt == 2'd3) ? 2'd2 : fetch_cnt;
  wire [1:0] n_in = flush ? 2'd0 :
                    (free_slots < CW'(want)) ? free_slots[1:0] : want;

  wire go0 = !flush && (cnt != '0) && rdy(i0, rs_ready) && !hz(i0, reg_busy) &&
             (!i0[2] || !pipe_busy);
  wire go1 = go0 && (cnt >= CW'(2)) && !i0[2] && !i1[2] && rdy(i1, rs_ready) &&
             !hz(i1, reg_busy) && !dep(i0, i1);
  wire [1:0] n_out = {1'b0, go0} + {1'b0, go1};

  assign dsp_valid = {go1, go0};
  assign dsp_insn0 = i0;
  assign dsp_insn1 = i1;
  assign dsp_unit0 = i0[1:0];
  assign dsp_unit1 = i1[1:0];

  always_ff @(posedge clk) begin
    if (n_in != 2'd0) q[wr] <= fetch_insn0;
    if (n_in == 2'd2) q[wr1] <= fetch_insn1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd  <= '0;
      wr  <= '0;
      cnt <= '0;
    end else begin
      rd  <= (n_out == 2'd2) ? nxt(rd1) : (n_out == 2'd1) ? rd1 : rd;
      wr  <= (n_in  == 2'd2) ? nxt(wr1) : (n_in  == 2'd1) ? wr1 : wr;
      cnt <= cnt + CW'(n_in) - CW'(n_out);
    end
  end
endmodule

// File: rtl/iq_dispatch2_chk.sv
module iq_dispatch2_chk #(
  parameter int DEPTH = 6,
  parameter int RW    = 5,
  parameter int PW    = 8,
  localparam int IW   = 6 + 3*RW + PW,
  localparam int NREG = 1 << RW,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic [1:0]    fetch_cnt,
  input logic [CW-1:0] free_slots,
  input logic [2:0]    rs_ready,
  input logic [NREG-1:0] reg_busy,
  input logic          pipe_busy,
  input logic [1:0]    dsp_valid,
  input logic [1:0]    dsp_unit0,
  input logic [IW-1:0] dsp_insn0
);
  localparam int S1LO = 5 + RW;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    free_slots <= CW'(DEPTH)); // R1

  AST_DRAIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && fetch_cnt == 2'd0) |=> free_slots ==
      $past(free_slots) + CW'($past(dsp_valid[0])) + CW'($past(dsp_valid[1]))); // R3

  AST_LANE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid[1] |-> dsp_valid[0]); // R7

  AST_STATION_READY: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid[0] |-> ((dsp_unit0 == 2'd0) ? rs_ready[0] :
                      (dsp_unit0 == 2'd1) ? rs_ready[1] : rs_ready[2])); // R4

  AST_SRC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid[0] && dsp_insn0[4+RW]) |-> !reg_busy[dsp_insn0[S1LO +: RW]]); // R5

  AST_SER_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid[0] && dsp_insn0[2]) |-> (!dsp_valid[1] && !pipe_busy)); // R8

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> free_slots == CW'(DEPTH)); // R9

  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> dsp_valid == 2'b00); // R9
endmodule

bind iq_dispatch2 iq_dispatch2_chk #(.DEPTH(DEPTH), .RW(RW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_cnt(fetch_cnt),
  .free_slots(free_slots), .rs_ready(rs_ready), .reg_busy(reg_busy),
  .pipe_busy(pipe_busy), .dsp_valid(dsp_valid), .dsp_unit0(dsp_unit0),
  .dsp_insn0(dsp_insn0)
);

// File: tb/iq_dispatch2_tb.sv
module iq_dispatch2_tb;
  localparam int IW = 29;
  logic clk = 0, rst_n = 0, flush = 0, pipe_busy = 0;
  logic [1:0] fetch_cnt = 0;
  logic [IW-1:0] fetch_insn0 = 0, fetch_insn1 = 0;
  logic [2:0] rs_ready = 0;
  logic [31:0] reg_busy = 0;
  logic [2:0] free_slots;
  logic [1:0] dsp_valid, dsp_unit0, dsp_unit1;
  logic [IW-1:0] dsp_insn0, dsp_insn1;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  iq_dispatch2 u_dut (.*);

  function automatic logic [IW-1:0] mk(input logic [1:0] u, input logic s,
      input logic hd, input logic [4:0] d, input logic h1, input logic [4:0] s1,
      input logic h2, input logic [4:0] s2, input logic [7:0] pl);
    return {pl, s2, h2, s1, h1, d, hd, s, u};
  endfunction
  function automatic logic [IW-1:0] pl(input logic [7:0] p);
    return mk(2'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, p);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic push(input logic [1:0] n, input logic [IW-1:0] a, input logic [IW-1:0] b);
    fetch_cnt = n; fetch_insn0 = a; fetch_insn1 = b;
    tick();
    fetch_cnt = 0;
  endtask

  task automatic clean();
    rs_ready = 0; reg_busy = 0; pipe_busy = 0; flush = 1;
    tick();
    flush = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset free", free_slots, 6);
    chk("R3 reset valid", dsp_valid, 0);
  endtask

  task automatic t_fill();
    clean();
    push(2, pl(1), pl(2));  chk("R1 free after 2", free_slots, 4);
    push(3, pl(3), pl(4));  chk("R2 cnt3 clamps", free_slots, 2);
    push(2, pl(5), pl(6));  chk("R1 full", free_slots, 0);
    push(2, pl(7), pl(8));  chk("R2 full ignores", free_slots, 0);
    rs_ready = 3'b111; #1;
    chk("R3 pair valid", dsp_valid, 3);
    chk("R3 lane0 oldest", dsp_insn0[28:21], 1);
    chk("R3 lane1", dsp_insn1[28:21], 2);
    tick();
    chk("R3 next pair", {dsp_insn0[28:21], dsp_insn1[28:21]}, 16'h0304);
    chk("R1 free 2", free_slots, 2);
    tick();
    chk("R3 last pair", {dsp_insn0[28:21], dsp_insn1[28:21]}, 16'h0506);
    tick();
    chk("R2 overflow dropped", dsp_valid, 0);
    chk("R1 empty", free_slots, 6);
  endtask

  task automatic t_partial();
    clean();
    push(2, pl(1), pl(2)); push(2, pl(3), pl(4)); push(1, pl(5), pl(0));
    push(2, pl(6), pl(7));
    chk("R2 partial accept", free_slots, 0);
    rs_ready = 3'b111; tick(); tick(); #1;
    chk("R2 partial kept older", dsp_insn0[28:21], 5);
    chk("R2 partial pair", {dsp_insn1[28:21]}, 6);
    tick();
    chk("R2 partial dropped younger", dsp_valid, 0);
  endtask

  task automatic t_units();
    clean();
    push(1, mk(2'd1, 0, 0, 0, 0, 0, 0, 0, 8'd9), 0);
    rs_ready = 3'b101; #1;
    chk("R4 lsu not ready", dsp_valid, 0);
    rs_ready = 3'b010; #1;
    chk("R4 lsu ready", dsp_valid, 1);
    chk("R4 lsu unit", dsp_unit0, 1);
    tick();
    rs_ready = 0;
    push(1, mk(2'd3, 0, 0, 0, 0, 0, 0, 0, 8'd10), 0);
    rs_ready = 3'b011; #1;
    chk("R4 code3 uses sys ready", dsp_valid, 0);
    rs_ready = 3'b100; #1;
    chk("R4 code3 go", dsp_valid, 1);
    chk("R4 code3 unit", dsp_unit0, 3);
  endtask

  task automatic t_hazard();
    clean();
    push(1, mk(0, 0, 0, 0, 1, 5'd7, 0, 0, 8'd11), 0);
    rs_ready = 3'b111; reg_busy = 32'h80; #1;
    chk("R5 src busy", dsp_valid, 0);
    reg_busy = 0; #1;
    chk("R5 src free", dsp_valid, 1);
    tick();
    rs_ready = 0;
    push(1, mk(0, 0, 1, 5'd9, 0, 0, 1, 5'd2, 8'd12), 0);
    rs_ready = 3'b111; reg_busy = 32'h200; #1;
    chk("R5 dst busy", dsp_valid, 0);
    reg_busy = 32'h4; #1;
    chk("R5 src2 busy", dsp_valid, 0);
    reg_busy = 0; #1;
    chk("R5 all free", dsp_valid, 1);
  endtask

  task automatic t_pair();
    clean();
    push(2, mk(0, 0, 1, 5'd5, 0, 0, 0, 0, 8'd20), mk(1, 0, 0, 0, 0, 0, 1, 5'd5, 8'd21));
    rs_ready = 3'b111; #1;
    chk("R6 raw pair", dsp_valid, 1);
    tick();
    chk("R6 younger next", dsp_valid, 1);
    chk("R6 younger payload", dsp_insn0[28:21], 21);
    tick();
    rs_ready = 0;
    push(2, mk(0, 0, 1, 5'd6, 0, 0, 0, 0, 8'd22), mk(1, 0, 1, 5'd6, 0, 0, 0, 0, 8'd23));
    rs_ready = 3'b111; #1;
    chk("R6 waw pair", dsp_valid, 1);
  endtask

  task automatic t_order();
    clean();
    push(2, mk(0, 0, 0, 0, 1, 5'd3, 0, 0, 8'd30), mk(1, 0, 0, 0, 0, 0, 0, 0, 8'd31));
    rs_ready = 3'b111; reg_busy = 32'h8; #1;
    chk("R7 head hazard blocks younger", dsp_valid, 0);
    reg_busy = 0; rs_ready = 3'b010; #1;
    chk("R7 head not ready blocks younger", dsp_valid, 0);
    rs_ready = 3'b011; #1;
    chk("R7 release", dsp_valid, 3);
  endtask

  task automatic t_serial();
    clean();
    push(2, mk(2, 1, 0, 0, 0, 0, 0, 0, 8'd40), pl(41));
    rs_ready = 3'b111; pipe_busy = 1; #1;
    chk("R8 serial waits pipe", dsp_valid, 0);
    pipe_busy = 0; #1;
    chk("R8 serial alone", dsp_valid, 1);
    tick();
    chk("R8 follower next", dsp_insn0[28:21], 41);
    tick();
    rs_ready = 0;
    push(2, pl(42), mk(2, 1, 0, 0, 0, 0, 0, 0, 8'd43));
    rs_ready = 3'b111; #1;
    chk("R8 serial second held", dsp_valid, 1);
    tick();
    chk("R8 serial at head", dsp_valid, 1);
    chk("R8 serial payload", dsp_insn0[28:21], 43);
  endtask

  task automatic t_flush();
    clean();
    push(2, pl(50), pl(51)); push(2, pl(52), pl(53));
    rs_ready = 3'b111; flush = 1; fetch_cnt = 2; fetch_insn0 = pl(54); fetch_insn1 = pl(55); #1;
    chk("R9 no dispatch in flush", dsp_valid, 0);
    tick();
    flush = 0; fetch_cnt = 0; #1;
    chk("R9 empty after flush", free_slots, 6);
    chk("R9 fetch ignored", dsp_valid, 0);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) tick();
    rst_n = 1;
    t_reset();
    t_fill();
    t_partial();
    t_units();
    t_hazard();
    t_pair();
    t_order();
    t_serial();
    t_flush();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule